// File: doc/BRIEF.md
# Strap-Configured Host Bus Slave with Byte-Lane Remapping

This block is a synchronous slave port through which an external microcontroller reaches an internal word-wide register file and a small FIFO. The host opens a bus operation by pulling an active-low start strobe, gives a read/write flag, a 7-bit byte address and a 16-bit data bus, and gets back an active-low cycle acknowledge. Static strap inputs set the bus personality. They select a narrow 8-bit data path or the full 16-bit path, a handshake acknowledge or a pulsed one, an alternate single-strobe bus mode in which the width and handshake straps carry a two-bit transfer size, and little-endian byte ordering in either address-invariant or data-invariant form.

In the alternate mode the slave checks every request. When the transfer size is one it does not support, or when the start strobe stays low for a second clock, it drives a one-clock active-low error pulse in place of an acknowledge and leaves the targets untouched. The register file and the FIFO behind the port are simple behavioural targets. Read data comes out on a separate output bus that stays valid from the acknowledge until the next read.

Address numbering: `addr[0]` is the least significant address bit and selects the byte within a word. `addr[6:1]` is the word index. `wdata[15:8]`/`rdata[15:8]` form the upper byte lane, which carries the most significant data bits.

Top module: `mcu_bus_slave`

## Requirements
- R1: While `rst_n` is low at a clock edge, `ack_n` and `err_n` go high and `rdata` goes to 0. Registers reset to 0 and the FIFO resets to empty.
- R2: Outside the alternate mode, a strobe (`cs_n` low) sampled at edge E performs the access at E, and `ack_n` is low in the cycle after E. With all byte straps low, a 16-bit write stores `wdata` unchanged in the register at word index `addr[6:1]` (indices 0 to 15). A 16-bit read returns that register on `rdata`.
- R3: With `strap_le`=1 and `strap_dinv`=0 (address-invariant), 16-bit data is lane-swapped on the way in and again on the way out. A word written as 16'h1234 is therefore stored as 16'h3412.
- R4: With `strap_le`=1 and `strap_dinv`=1 (data-invariant), 16-bit data passes without a swap. When `strap_le`=0, `strap_dinv` has no effect.
- R5: With `strap_narrow`=1 (8-bit mode), only `wdata[15:8]` is used. `addr[0]` picks the register byte: with `strap_le`=0, `addr[0]`=0 picks bits 15:8 and 1 picks bits 7:0, and with `strap_le`=1 the choice is reversed. The other byte is kept. A byte read returns the byte on `rdata[15:8]` with `rdata[7:0]`=0.
- R6: With `strap_hshake`=1 (and the alternate mode off), `ack_n` stays low until `cs_n` is sampled high. With `strap_hshake`=0, `ack_n` is low for exactly one cycle even if `cs_n` stays low.
- R7: Word index 63 (`addr[6:1]`=6'h3F) is a 4-entry FIFO. Writes push, reads pop in arrival order, and a write to a full FIFO is acknowledged and dropped. A read while the FIFO is empty gets no acknowledge as long as it stays empty.
- R8: With `strap_alt`=1, size = {`strap_hshake`,`strap_narrow`}: 2'b01 is a byte transfer and 2'b10 is a 16-bit transfer. A strobe sampled low at E and high at E+1 makes the access at E+1, using the address and data sampled at E, and `ack_n` is low in the cycle after E+1.
- R9: In the alternate mode, size 2'b00 or 2'b11 at the strobe edge E drives `err_n` low for exactly one cycle, the cycle after E. No acknowledge is given and nothing is written. `ack_n` and `err_n` are never low together.
- R10: In the alternate mode, a strobe sampled low at E and again at E+1 drives `err_n` low for one cycle, the cycle after E+1. No acknowledge is given and nothing is written.
- R11: Word indices 16 to 62 are unmapped. Writes to them are acknowledged and ignored, and reads return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low cycle start strobe |
| rd_wr | input | 1 | 1 = read from slave, 0 = write to slave |
| addr | input | 7 | Byte address, bit 0 selects the byte |
| wdata | input | 16 | Host write data, bits 15:8 are the upper lane |
| rdata | output | 16 | Read data, valid from acknowledge onward |
| ack_n | output | 1 | Active-low cycle acknowledge |
| err_n | output | 1 | Active-low one-cycle transfer error |
| strap_narrow | input | 1 | 8-bit bus select, size bit 0 in alternate mode |
| strap_hshake | input | 1 | Handshake acknowledge select, size bit 1 in alternate mode |
| strap_alt | input | 1 | Alternate single-strobe bus mode |
| strap_le | input | 1 | Little-endian byte ordering |
| strap_dinv | input | 1 | Data-invariant (1) or address-invariant (0) when little-endian |

## Verification
Outside the alternate mode the acknowledge is due one clock after the edge that samples the strobe. In the alternate mode the acknowledge and the overlong-strobe error are due two clocks after that edge, and the size error is due after one clock. Every driver call records the edge that will sample its strobe and queues the expected event with that due cycle and, for reads, the expected data from a model built from the requirements. The monitor samples on falling edges, pops the queue at each acknowledge fall or error pulse, and compares the event kind, the cycle number and `rdata`. Hold-off, single-pulse and error-only-once behaviours are checked directly on the following falling edges while the strobe is still held.

// File: rtl/mbs_pkg.sv
// Package: shared widths, controller states, the request record and the lane
// swap helper for the host bus slave. Assumes a 7-bit byte address and a
// 16-bit data bus split into two 8-bit lanes.
package mbs_pkg;
    localparam int AW = 7;
    localparam int DW = 16;
    localparam int BW = DW / 2;
    localparam int XW = AW - 1;

    // Word index of the FIFO window (top of the word space).
    localparam logic [XW-1:0] FIFO_WIDX = '1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_RETRY,
        ST_HOLD,
        ST_REL
    } mbs_state_t;

    typedef struct packed {
        logic          rd;
        logic          bytew;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } mbs_req_t;

    // Exchange the upper and lower byte lanes of a word.
    function automatic logic [DW-1:0] swap_lanes(input logic [DW-1:0] w);
        return {w[BW-1:0], w[DW-1:BW]};
    endfunction
endpackage

// File: rtl/mbs_lanes.sv
// Lane mapper: turns a host request into the word written to a target and
// the target's raw word into the value shown on the read bus. Purely
// combinational. Assumes that byte data always travels on the upper lane and
// that the FIFO holds byte transfers in its low byte.
module mbs_lanes
    import mbs_pkg::*;
(
    input  logic [AW-1:0] addr,
    input  logic          bytew,
    input  logic [DW-1:0] wdata,
    input  logic          le,
    input  logic          dinv,
    input  logic [DW-1:0] raw,
    output logic [DW-1:0] wr_word,
    output logic [DW-1:0] rd_bus
);
    logic          is_fifo;
    logic          swap_en;
    logic          hi_sel;
    logic [BW-1:0] wbyte;
    logic [BW-1:0] rbyte;

    // Decode the lane choice and build both the write word and the read value.
    always_comb begin
        is_fifo = (addr[AW-1:1] == FIFO_WIDX);
        swap_en = le & ~dinv;
        hi_sel  = ~(addr[0] ^ le);
        wbyte   = wdata[DW-1:BW];

        if (!bytew)
            wr_word = swap_en ? swap_lanes(wdata) : wdata;
        else if (is_fifo)
            wr_word = {{BW{1'b0}}, wbyte};
        else if (hi_sel)
            wr_word = {wbyte, raw[BW-1:0]};
        else
            wr_word = {raw[DW-1:BW], wbyte};

        if (is_fifo)
            rbyte = raw[BW-1:0];
        else if (hi_sel)
            rbyte = raw[DW-1:BW];
        else
            rbyte = raw[BW-1:0];

        if (bytew)
            rd_bus = {rbyte, {BW{1'b0}}};
        else
            rd_bus = swap_en ? swap_lanes(raw) : raw;
    end
endmodule

// File: rtl/mbs_target.sv
// Behavioural targets: a register file of NREGS words and a FIFO of FDEPTH
// words at the top word index. Writes happen at the clock edge on wr_en and
// pops on pop_en. Assumes that FDEPTH is a power of two and that NREGS is
// below the FIFO index. Unmapped indices read as zero.
module mbs_target
    import mbs_pkg::*;
#(
    parameter int NREGS  = 16,
    parameter int FDEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          pop_en,
    input  logic [XW-1:0] widx,
    input  logic [DW-1:0] wr_word,
    output logic [DW-1:0] raw,
    output logic          fifo_empty
);
    localparam int IW = (NREGS > 1) ? $clog2(NREGS) : 1;
    localparam int PW = (FDEPTH > 1) ? $clog2(FDEPTH) : 1;
    localparam int CW = PW + 1;
    localparam logic [CW-1:0] FULL_CNT = CW'(FDEPTH);

    logic [DW-1:0] regs [NREGS];
    logic [DW-1:0] fmem [FDEPTH];
    logic [PW-1:0] rptr, wptr;
    logic [CW-1:0] count;
    logic          is_fifo, mapped, push;

    // Classify the word index and pick the raw word for the lane mapper.
    always_comb begin
        is_fifo    = (widx == FIFO_WIDX);
        mapped     = !is_fifo && (32'(widx) < NREGS);
        push       = wr_en && is_fifo && (count != FULL_CNT);
        fifo_empty = (count == '0);
        if (is_fifo)
            raw = fmem[rptr];
        else if (mapped)
            raw = regs[widx[IW-1:0]];
        else
            raw = '0;
    end

    // Register file write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= '0;
        end else if (wr_en && mapped) begin
            regs[widx[IW-1:0]] <= wr_word;
        end
    end

    // FIFO storage.
    always_ff @(posedge clk) begin
        if (push) fmem[wptr] <= wr_word;
    end

    // FIFO pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr  <= '0;
            wptr  <= '0;
            count <= '0;
        end else begin
            if (push) wptr <= wptr + 1'b1;
            if (pop_en) rptr <= rptr + 1'b1;
            count <= count + CW'(push) - CW'(pop_en);
        end
    end

    // R7: the controller never pops an empty FIFO.
    a_r7_pop_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pop_en |-> !fifo_empty);

    // R7: occupancy stays within the FIFO depth.
    a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);
endmodule

// File: rtl/mbs_ctrl.sv
// Cycle controller: samples the strobe, checks alternate-mode requests,
// decides when an access happens, and drives the acknowledge and error
// outputs. Assumes that straps change only while no cycle is open. In the
// alternate mode the request is latched at the strobe edge and performed one
// clock later, once the strobe has been seen released.
module mbs_ctrl
    import mbs_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rd_wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          strap_narrow,
    input  logic          strap_hshake,
    input  logic          strap_alt,
    input  logic          fifo_empty,
    output mbs_req_t      cur_req,
    output logic          acc_go,
    output logic          ack_n,
    output logic          err_n
);
    mbs_state_t state, nxt;
    mbs_req_t   live, lat;
    logic [1:0] siz;
    logic       size_ok, blocked, try_acc, lat_load, ack_d, err_d;

    // Assemble the live request from the pins and select the active request.
    always_comb begin
        siz        = {strap_hshake, strap_narrow};
        size_ok    = (siz == 2'b01) || (siz == 2'b10);
        live.rd    = rd_wr;
        live.bytew = strap_alt ? (siz == 2'b01) : strap_narrow;
        live.addr  = addr;
        live.wdata = wdata;
        cur_req    = (state == ST_IDLE) ? live : lat;
        blocked    = cur_req.rd && (cur_req.addr[AW-1:1] == FIFO_WIDX) && fifo_empty;
    end

    // Next state, access decision and output drive values.
    always_comb begin
        nxt      = state;
        ack_d    = 1'b1;
        err_d    = 1'b1;
        lat_load = 1'b0;
        try_acc  = 1'b0;
        case (state)
            ST_IDLE: begin
                if (!cs_n) begin
                    if (strap_alt) begin
                        if (!size_ok) begin
                            err_d = 1'b0;
                            nxt   = ST_REL;
                        end else begin
                            lat_load = 1'b1;
                            nxt      = ST_CHECK;
                        end
                    end else begin
                        try_acc = 1'b1;
                        if (!blocked) begin
                            ack_d = 1'b0;
                            nxt   = strap_hshake ? ST_HOLD : ST_REL;
                        end
                    end
                end
            end
            ST_CHECK: begin
                if (!cs_n) begin
                    err_d = 1'b0;
                    nxt   = ST_REL;
                end else begin
                    try_acc = 1'b1;
                    if (!blocked) begin
                        ack_d = 1'b0;
                        nxt   = ST_REL;
                    end else begin
                        nxt = ST_RETRY;
                    end
                end
            end
            ST_RETRY: begin
                try_acc = 1'b1;
                if (!blocked) begin
                    ack_d = 1'b0;
                    nxt   = ST_REL;
                end
            end
            ST_HOLD: begin
                if (!cs_n) ack_d = 1'b0;
                else       nxt   = ST_IDLE;
            end
            ST_REL: begin
                if (cs_n) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
        acc_go = try_acc && !blocked;
    end

    // State, latched request and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            lat   <= '0;
            ack_n <= 1'b1;
            err_n <= 1'b1;
        end else begin
            state <= nxt;
            ack_n <= ack_d;
            err_n <= err_d;
            if (lat_load) lat <= live;
        end
    end

    // R9: an error pulse lasts a single cycle.
    a_r9_err_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        !err_n |=> err_n);

    // R9: acknowledge and error are never driven together.
    a_r9_no_ack_with_err: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ack_n && !err_n));

    // R8: an alternate-mode acknowledge follows an edge that saw the strobe released.
    a_r8_ack_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        (strap_alt && $fell(ack_n)) |-> $past(cs_n));

    // R10: a strobe still low at the check edge raises the error next cycle.
    a_r10_overlong_err: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHECK && !cs_n) |=> !err_n);

    // R6: a handshake acknowledge holds while the strobe stays low.
    a_r6_hold_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (!strap_alt && strap_hshake && !ack_n && !cs_n) |=> !ack_n);
endmodule

// File: rtl/mcu_bus_slave.sv
// Top of the host bus slave: joins the cycle controller, the lane mapper and
// the behavioural targets, and registers the read data bus. Assumes static
// straps and a synchronous host on the same clock.
module mcu_bus_slave
    import mbs_pkg::*;
#(
    parameter int NREGS  = 16,
    parameter int FDEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rd_wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          ack_n,
    output logic          err_n,
    input  logic          strap_narrow,
    input  logic          strap_hshake,
    input  logic          strap_alt,
    input  logic          strap_le,
    input  logic          strap_dinv
);
    mbs_req_t      cur_req;
    logic          acc_go, fifo_empty, wr_en, pop_en, fifo_sel;
    logic [DW-1:0] raw, wr_word, rd_bus;

    mbs_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_n         (cs_n),
        .rd_wr        (rd_wr),
        .addr         (addr),
        .wdata        (wdata),
        .strap_narrow (strap_narrow),
        .strap_hshake (strap_hshake),
        .strap_alt    (strap_alt),
        .fifo_empty   (fifo_empty),
        .cur_req      (cur_req),
        .acc_go       (acc_go),
        .ack_n        (ack_n),
        .err_n        (err_n)
    );

    mbs_lanes u_lanes (
        .addr    (cur_req.addr),
        .bytew   (cur_req.bytew),
        .wdata   (cur_req.wdata),
        .le      (strap_le),
        .dinv    (strap_dinv),
        .raw     (raw),
        .wr_word (wr_word),
        .rd_bus  (rd_bus)
    );

    // Split the controller's go signal into target write and FIFO pop.
    always_comb begin
        fifo_sel = (cur_req.addr[AW-1:1] == FIFO_WIDX);
        wr_en    = acc_go && !cur_req.rd;
        pop_en   = acc_go && cur_req.rd && fifo_sel;
    end

    mbs_target #(
        .NREGS  (NREGS),
        .FDEPTH (FDEPTH)
    ) u_target (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .pop_en     (pop_en),
        .widx       (cur_req.addr[AW-1:1]),
        .wr_word    (wr_word),
        .raw        (raw),
        .fifo_empty (fifo_empty)
    );

    // Capture read data at the access edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                   rdata <= '0;
        else if (acc_go && cur_req.rd) rdata <= rd_bus;
    end
endmodule

// File: tb/sim_mcu_bus_slave.sv
`timescale 1ns/1ps
module sim_mcu_bus_slave;
    logic        clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, rd_wr = 1'b0;
    logic [6:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic        s_narrow = 0, s_hshake = 0, s_alt = 0, s_le = 0, s_dinv = 0;
    logic [15:0] rdata;
    logic        ack_n, err_n;

    mcu_bus_slave u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_wr(rd_wr), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ack_n(ack_n), .err_n(err_n),
        .strap_narrow(s_narrow), .strap_hshake(s_hshake), .strap_alt(s_alt),
        .strap_le(s_le), .strap_dinv(s_dinv)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int          kind;   // 0 = acknowledge, 1 = error
        logic [15:0] data;
        bit          chk;
        int          due;
        string       tag;
    } exp_t;
    exp_t sbq[$];

    int n_chk = 0, n_fail = 0;
    bit mon_on = 0;
    logic ack_prev = 1'b1;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    // Monitor: pop and compare one expected item per acknowledge fall or error pulse.
    always @(negedge clk) begin
        exp_t e;
        int   k;
        if (mon_on && ((!ack_n && ack_prev) || !err_n)) begin
            k = !err_n ? 1 : 0;
            if (sbq.size() == 0) begin
                n_chk++;
                n_fail++;
                $display("FAIL R9 unexpected event: actual kind %0d expected none", k);
            end else begin
                e = sbq.pop_front();
                check({e.tag, " kind"}, 32'(k), 32'(e.kind));
                check({e.tag, " cycle"}, 32'(cyc), 32'(e.due));
                if (e.chk) check({e.tag, " data"}, 32'(rdata), 32'(e.data));
            end
        end
        ack_prev = ack_n;
    end

    // Reference model of the targets, written from the requirements.
    logic [15:0] mregs [16];
    logic [15:0] mfifo [$];

    function automatic logic [15:0] m_raw(input logic [6:0] a);
        logic [5:0] wi = a[6:1];
        if (wi == 6'h3F) return (mfifo.size() != 0) ? mfifo[0] : 16'h0;
        if (wi < 16) return mregs[wi[3:0]];
        return 16'h0;
    endfunction

    function automatic logic [15:0] m_read(input logic [6:0] a, input bit bw);
        logic [15:0] w = m_raw(a);
        bit hi = (a[0] == s_le);
        if (bw) begin
            if (a[6:1] == 6'h3F) return {w[7:0], 8'h00};
            return hi ? {w[15:8], 8'h00} : {w[7:0], 8'h00};
        end
        return (s_le && !s_dinv) ? {w[7:0], w[15:8]} : w;
    endfunction

    task automatic m_write(input logic [6:0] a, input bit bw, input logic [15:0] d);
        logic [15:0] w = m_raw(a);
        logic [15:0] nw;
        bit hi = (a[0] == s_le);
        if (!bw) nw = (s_le && !s_dinv) ? {d[7:0], d[15:8]} : d;
        else if (a[6:1] == 6'h3F) nw = {8'h00, d[15:8]};
        else nw = hi ? {d[15:8], w[7:0]} : {w[15:8], d[15:8]};
        if (a[6:1] == 6'h3F) begin
            if (mfifo.size() < 4) mfifo.push_back(nw);
        end else if (a[6:1] < 16) begin
            mregs[a[4:1]] = nw;
        end
    endtask

    task automatic m_pop(input logic [6:0] a);
        if (a[6:1] == 6'h3F && mfifo.size() != 0) void'(mfifo.pop_front());
    endtask

    function automatic logic [6:0] ad(input int wi, input int b);
        return {6'(wi), 1'(b)};
    endfunction

    // Driver for a cycle outside the alternate mode.
    task automatic nat_cycle(input bit rd, input logic [6:0] a, input logic [15:0] d,
                             input logic [15:0] expd, input string tag);
        exp_t e;
        int w = 0;
        @(negedge clk);
        rd_wr = rd; addr = a; wdata = d; cs_n = 1'b0;
        e.kind = 0; e.data = expd; e.chk = rd; e.due = cyc + 1; e.tag = tag;
        sbq.push_back(e);
        do begin @(negedge clk); w++; end while (ack_n && w < 20);
        if (s_hshake) begin
            repeat (2) begin
                @(negedge clk);
                check({tag, " R6 ack held"}, 32'(ack_n), 32'd0);
            end
        end else begin
            @(negedge clk);
            check({tag, " R6 single ack"}, 32'(ack_n), 32'd1);
        end
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic nat_wr(input logic [6:0] a, input logic [15:0] d, input string tag);
        m_write(a, s_narrow, d);
        nat_cycle(1'b0, a, d, 16'h0, tag);
    endtask

    task automatic nat_rd(input logic [6:0] a, input string tag);
        logic [15:0] x = m_read(a, s_narrow);
        m_pop(a);
        nat_cycle(1'b1, a, 16'h0, x, tag);
    endtask

    // Driver for an alternate-mode cycle; size straps are driven with the strobe.
    task automatic alt_cycle(input logic [1:0] siz, input bit rd, input logic [6:0] a,
                             input logic [15:0] d, input bit long_strobe, input string tag);
        exp_t e;
        bit ok = (siz == 2'b01) || (siz == 2'b10);
        @(negedge clk);
        s_hshake = siz[1]; s_narrow = siz[0];
        rd_wr = rd; addr = a; wdata = d; cs_n = 1'b0;
        e.tag = tag; e.chk = 0; e.data = 16'h0;
        if (!ok) begin
            e.kind = 1; e.due = cyc + 1;
        end else if (long_strobe) begin
            e.kind = 1; e.due = cyc + 2;
        end else begin
            e.kind = 0; e.due = cyc + 2;
            if (rd) begin
                e.chk = 1; e.data = m_read(a, siz == 2'b01); m_pop(a);
            end else begin
                m_write(a, siz == 2'b01, d);
            end
        end
        sbq.push_back(e);
        @(negedge clk);
        if (long_strobe) @(negedge clk);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    bit done = 0;

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog: actual hung expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        bit ok;
        logic [15:0] keep;
        for (int i = 0; i < 16; i++) mregs[i] = 16'h0;

        repeat (3) @(negedge clk);
        check("R1 reset ack_n", 32'(ack_n), 32'd1);
        check("R1 reset err_n", 32'(err_n), 32'd1);
        check("R1 reset rdata", 32'(rdata), 32'd0);
        rst_n = 1'b1;
        mon_on = 1;
        @(negedge clk);
        check("R1 idle after reset", 32'(ack_n), 32'd1);

        // R2: big-endian 16-bit write and read
        nat_wr(ad(3, 0), 16'hA1B2, "R2 write");
        nat_rd(ad(3, 0), "R2 read");
        nat_wr(ad(0, 0), 16'h0F0F, "R2 write idx0");
        nat_rd(ad(0, 0), "R2 read idx0");

        // R3: address-invariant swap both ways
        s_le = 1; s_dinv = 0;
        nat_wr(ad(4, 0), 16'h1234, "R3 write");
        nat_rd(ad(4, 0), "R3 read swapped back");
        s_le = 0;
        nat_rd(ad(4, 0), "R3 stored form");
        check("R3 stored as swapped", 32'(rdata), 32'h3412);

        // R4: data-invariant passes unchanged; dinv ignored when le low
        s_le = 1; s_dinv = 1;
        nat_wr(ad(5, 0), 16'h5678, "R4 write dinv");
        s_le = 0; s_dinv = 0;
        nat_rd(ad(5, 0), "R4 read dinv");
        check("R4 no swap stored", 32'(rdata), 32'h5678);
        s_dinv = 1;
        nat_wr(ad(6, 0), 16'h9ABC, "R4 dinv ignored write");
        s_dinv = 0;
        nat_rd(ad(6, 0), "R4 dinv ignored read");

        // R5: 8-bit mode byte select and merge
        s_narrow = 1;
        nat_wr(ad(3, 1), 16'h5C77, "R5 byte write low");
        nat_rd(ad(3, 0), "R5 byte read be");
        s_le = 1;
        nat_rd(ad(3, 0), "R5 byte read le");
        nat_wr(ad(3, 1), 16'hEE00, "R5 byte write le");
        s_le = 0; s_narrow = 0;
        nat_rd(ad(3, 0), "R5 merged word");
        check("R5 merged value", 32'(rdata), 32'hEE5C);

        // R6: handshake hold
        s_hshake = 1;
        nat_wr(ad(2, 0), 16'h2468, "R6 hshake write");
        nat_rd(ad(2, 0), "R6 hshake read");
        s_hshake = 0;

        // R7: FIFO order and empty hold-off
        nat_wr(ad(63, 0), 16'h1111, "R7 push1");
        nat_wr(ad(63, 0), 16'h2222, "R7 push2");
        nat_rd(ad(63, 0), "R7 pop1");
        nat_rd(ad(63, 0), "R7 pop2");
        keep = rdata;
        @(negedge clk);
        rd_wr = 1; addr = ad(63, 0); cs_n = 1'b0;
        ok = 1;
        repeat (6) begin
            @(negedge clk);
            if (!ack_n) ok = 0;
        end
        check("R7 empty read held off", 32'(ok), 32'd1);
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R7 empty read keeps rdata", 32'(rdata), 32'(keep));

        // R11: unmapped index
        nat_wr(ad(32, 0), 16'h7777, "R11 unmapped write");
        nat_rd(ad(32, 0), "R11 unmapped read");
        check("R11 reads zero", 32'(rdata), 32'd0);

        // R8: alternate mode transfers
        s_alt = 1;
        alt_cycle(2'b10, 0, ad(7, 0), 16'hBEEF, 0, "R8 alt half write");
        alt_cycle(2'b10, 1, ad(7, 0), 16'h0, 0, "R8 alt half read");
        alt_cycle(2'b01, 0, ad(7, 0), 16'h1100, 0, "R8 alt byte write");
        alt_cycle(2'b10, 1, ad(7, 0), 16'h0, 0, "R8 alt merged read");
        check("R8 merged value", 32'(rdata), 32'h11EF);

        // R9: unsupported sizes
        alt_cycle(2'b00, 0, ad(8, 0), 16'hFFFF, 0, "R9 size00 err");
        alt_cycle(2'b11, 0, ad(8, 0), 16'hFFFF, 0, "R9 size11 err");
        alt_cycle(2'b10, 1, ad(8, 0), 16'h0, 0, "R9 no write");
        check("R9 reg untouched", 32'(rdata), 32'd0);

        // R10: overlong strobe
        alt_cycle(2'b10, 0, ad(9, 0), 16'hCAFE, 1, "R10 overlong err");
        alt_cycle(2'b10, 1, ad(9, 0), 16'h0, 0, "R10 no write");
        check("R10 reg untouched", 32'(rdata), 32'd0);
        s_alt = 0; s_narrow = 0; s_hshake = 0;

        repeat (5) @(negedge clk);
        check("R2 all events seen", 32'(sbq.size()), 32'd0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule